// File: doc/BRIEF.md
# SPI Chip-Select Expander

This block lets one SPI controller address sixteen peripherals while still using only its four usual wires: data out, serial clock, one select line and data in. The select line has two jobs. While the controller holds it low, each rising serial-clock edge moves one bit from the data-out wire into a short address shift register. While the controller holds it high, it acts as the transfer strobe. The stored address then picks exactly one peripheral, pulls that peripheral's active-low select down, and routes that peripheral's serial output back to the controller's data-in.

The block runs on a system clock. The serial clock, select line and data-out are each passed through a two-flop synchroniser. The register advances on a detected rising edge of the synchronised serial clock. It is never clocked by the serial clock itself. As seen by the controller, the select line is active high during a peripheral transfer and low during address loading.

Top module: `spi_cs_expander`

## Requirements
- R1: After the active-low reset, every bit of `per_sel_n` is 1, `ctl_miso` is 0, and the stored address is 0.
- R2: While `ctl_sel` is low, every rising edge of `ctl_sclk` shifts the value of `ctl_mosi` into bit 0 of the address register and moves the older bits up by one. Bits are sent MSB first. After four shifts, the four bits just sent form the address.
- R3: While `ctl_sel` is high, edges on `ctl_sclk` and changes on `ctl_mosi` leave the stored address unchanged. The next frame therefore selects the same peripheral.
- R4: The register holds 6 bits, but only its low 4 bits form the address. Bits shifted in more than four positions earlier have no effect on selection.
- R5: Address bit 3 picks the bank: 0 selects bank 0 (peripherals 0–7) and 1 selects bank 1 (peripherals 8–15). Bits 2..0 pick the peripheral inside that bank, so the peripheral index equals the 4-bit address.
- R6: While the synchronised `ctl_sel` is high, exactly one bit of `per_sel_n` is 0: the bit at the address. While it is low, all sixteen bits are 1. `per_sel_n` follows `ctl_sel` after two system-clock cycles.
- R7: While `ctl_sel` is high, `ctl_miso` equals `per_miso[address]`.
- R8: While `ctl_sel` is low, `ctl_miso` is 0, whatever values appear on `per_miso`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_sclk | input | 1 | Serial clock from the controller |
| ctl_sel | input | 1 | Controller select: low loads the address, high frames a transfer |
| ctl_mosi | input | 1 | Serial data out from the controller |
| ctl_miso | output | 1 | Serial data in to the controller |
| per_sel_n | output | 16 | Active-low selects, one per peripheral |
| per_miso | input | 16 | Serial outputs of the peripherals |

## Verification
The bench sends addresses of random length, from one to eight bits. A design that mis-sized the register, shifted in the wrong direction, or used the upper bits would then select the wrong peripheral once the bench's model of the bit history is compared. During each frame the bench toggles the serial clock and data-out. A design that kept shifting while the select line was high would address a different peripheral in the next frame. Addresses 7, 8 and 15 probe the bank boundary, where a wrong polarity on bank enable would wake the wrong half or both halves. Random `per_miso` patterns, applied both in and out of a frame, expose a mux that reads the wrong input or drives data while idle.

// File: rtl/csx_pkg.sv
// Shared types and defaults for the chip-select expander.
package csx_pkg;
    localparam int unsigned DEF_SR_LEN  = 6;  // shift register length
    localparam int unsigned DEF_ADDR_W  = 4;  // bits used as address
    localparam int unsigned DEF_BANK_W  = 3;  // address bits inside one bank
    localparam int unsigned DEF_SYNC_N  = 2;  // synchroniser stages

    // Controller wires after synchronisation.
    typedef struct packed {
        logic sclk_rise;
        logic sel;
        logic mosi;
    } ctl_sync_t;
endpackage

// File: rtl/csx_ctl_sync.sv
// Synchronises the controller's serial clock, select and data-out into the
// system clock domain and detects rising edges of the serial clock.
// Assumes the serial clock is slower than clk/4 and that data-out is stable
// before the serial clock rises.
module csx_ctl_sync
    import csx_pkg::*;
#(
    parameter int unsigned SYNC_N = DEF_SYNC_N
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sclk_in,
    input  logic      sel_in,
    input  logic      mosi_in,
    output ctl_sync_t sync_o
);
    logic [SYNC_N-1:0] sclk_pipe;
    logic [SYNC_N-1:0] sel_pipe;
    logic [SYNC_N-1:0] mosi_pipe;
    logic              sclk_last;

    // Shift each raw input through its synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_pipe <= '0;
            sel_pipe  <= '0;
            mosi_pipe <= '0;
            sclk_last <= 1'b0;
        end else begin
            sclk_pipe <= {sclk_pipe[SYNC_N-2:0], sclk_in};
            sel_pipe  <= {sel_pipe[SYNC_N-2:0],  sel_in};
            mosi_pipe <= {mosi_pipe[SYNC_N-2:0], mosi_in};
            sclk_last <= sclk_pipe[SYNC_N-1];
        end
    end

    // Present the synchronised values and the serial-clock rising edge.
    always_comb begin
        sync_o.sel       = sel_pipe[SYNC_N-1];
        sync_o.mosi      = mosi_pipe[SYNC_N-1];
        sync_o.sclk_rise = sclk_pipe[SYNC_N-1] & ~sclk_last;
    end
endmodule

// File: rtl/csx_addr_shift.sv
// Address shift register. While the select is low, each serial-clock rising
// edge shifts data-out in at bit 0, so bits sent MSB first end up in order.
// The low ADDR_W bits form the address; the rest only carry history.
module csx_addr_shift
    import csx_pkg::*;
#(
    parameter int unsigned SR_LEN = DEF_SR_LEN,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_sync_t         sync_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [SR_LEN-1:0] sr_q;

    // Shift on a serial-clock rise only while the select is low; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (!sync_i.sel && sync_i.sclk_rise) begin
            sr_q <= {sr_q[SR_LEN-2:0], sync_i.mosi};
        end
    end

    // Expose the address field.
    assign addr_o = sr_q[ADDR_W-1:0];
endmodule

// File: rtl/csx_bank_decode.sv
// Splits the address into a bank field and an in-bank index. Each bank drives
// its own active-low selects and its own return-data mux; only the enabled
// bank contributes to the data returned to the controller.
// Assumes ADDR_W > BANK_W.
module csx_bank_decode #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned BANK_W = 3
) (
    input  logic                    active,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [(1<<ADDR_W)-1:0]  per_miso,
    output logic [(1<<ADDR_W)-1:0]  per_sel_n,
    output logic                    miso
);
    localparam int unsigned BANK_N  = 1 << BANK_W;
    localparam int unsigned HI_W    = ADDR_W - BANK_W;
    localparam int unsigned N_BANKS = 1 << HI_W;

    logic [HI_W-1:0]    bank_sel;
    logic [BANK_W-1:0]  idx;
    logic [N_BANKS-1:0] bank_miso;

    assign bank_sel = addr[ADDR_W-1:BANK_W];
    assign idx      = addr[BANK_W-1:0];

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic              bank_en;
        logic [BANK_N-1:0] slice;

        // Enable this bank only for its bank-field value while framing.
        assign bank_en = active && (bank_sel == HI_W'(b));
        assign slice   = per_miso[b*BANK_N +: BANK_N];

        for (genvar k = 0; k < BANK_N; k++) begin : g_sel
            // Pull low the one select whose index matches.
            assign per_sel_n[b*BANK_N + k] = ~(bank_en && (idx == BANK_W'(k)));
        end

        // Bank-level mux: route the indexed peripheral, or 0 when disabled.
        assign bank_miso[b] = bank_en & slice[idx];
    end

    // At most one bank is enabled, so OR-combine the bank outputs.
    assign miso = |bank_miso;
endmodule

// File: rtl/spi_cs_expander.sv
// Top level: expands one controller select into 2**ADDR_W peripheral selects
// using an address shifted in while the select is low.
// Assumes synchronous active-low reset and a system clock at least four times
// the serial clock rate.
module spi_cs_expander
    import csx_pkg::*;
#(
    parameter int unsigned SR_LEN = DEF_SR_LEN,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned BANK_W = DEF_BANK_W,
    parameter int unsigned SYNC_N = DEF_SYNC_N
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_sclk,
    input  logic                   ctl_sel,
    input  logic                   ctl_mosi,
    output logic                   ctl_miso,
    output logic [(1<<ADDR_W)-1:0] per_sel_n,
    input  logic [(1<<ADDR_W)-1:0] per_miso
);
    ctl_sync_t         sync_s;
    logic [ADDR_W-1:0] addr_q;
    logic              sel_q;

    csx_ctl_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (ctl_sclk),
        .sel_in  (ctl_sel),
        .mosi_in (ctl_mosi),
        .sync_o  (sync_s)
    );

    csx_addr_shift #(.SR_LEN(SR_LEN), .ADDR_W(ADDR_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_s),
        .addr_o (addr_q)
    );

    assign sel_q = sync_s.sel;

    csx_bank_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dec (
        .active    (sel_q),
        .addr      (addr_q),
        .per_miso  (per_miso),
        .per_sel_n (per_sel_n),
        .miso      (ctl_miso)
    );
endmodule

// File: rtl/csx_checker.sv
// Assertion checker bound to the expander top level.
module csx_checker #(
    parameter int unsigned ADDR_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sel_q,
    input logic [ADDR_W-1:0]      addr_q,
    input logic [(1<<ADDR_W)-1:0] per_sel_n,
    input logic [(1<<ADDR_W)-1:0] per_miso,
    input logic                   ctl_miso
);
    AST_AT_MOST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~per_sel_n) <= 1); // R6
    AST_IDLE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |-> (&per_sel_n)); // R6
    AST_ADDRESSED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q |-> !per_sel_n[addr_q]); // R5
    AST_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q |=> $stable(addr_q)); // R3
    AST_MISO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q |-> (ctl_miso == per_miso[addr_q])); // R7
    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |-> !ctl_miso); // R8
endmodule

bind spi_cs_expander csx_checker #(.ADDR_W(ADDR_W)) u_csx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_q     (sel_q),
    .addr_q    (addr_q),
    .per_sel_n (per_sel_n),
    .per_miso  (per_miso),
    .ctl_miso  (ctl_miso)
);

// File: tb/spi_cs_expander_tb_top.sv
module spi_cs_expander_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_sclk = 1'b0;
    logic        ctl_sel = 1'b0;
    logic        ctl_mosi = 1'b0;
    logic        ctl_miso;
    logic [15:0] per_sel_n;
    logic [15:0] per_miso = '0;

    int unsigned checks = 0;
    int unsigned errors = 0;
    logic [5:0]  model_sr = '0;   // bench copy of the shift history
    bit          done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    spi_cs_expander dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_sclk  (ctl_sclk),
        .ctl_sel   (ctl_sel),
        .ctl_mosi  (ctl_mosi),
        .ctl_miso  (ctl_miso),
        .per_sel_n (per_sel_n),
        .per_miso  (per_miso)
    );

    function automatic logic [15:0] exp_sel(input logic [3:0] a, input bit on);
        exp_sel = on ? ~(16'h1 << a) : 16'hFFFF;
    endfunction

    function automatic logic exp_miso(input logic [3:0] a, input bit on,
                                      input logic [15:0] pm);
        exp_miso = on ? pm[a] : 1'b0;
    endfunction

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Shift n bits of val MSB first while the select is low.
    task automatic send_bits(input int n, input logic [7:0] val);
        for (int i = n - 1; i >= 0; i--) begin
            ctl_mosi = val[i];
            wait_clk(3);
            ctl_sclk = 1'b1;
            wait_clk(3);
            ctl_sclk = 1'b0;
            wait_clk(2);
            model_sr = {model_sr[4:0], val[i]};
        end
    endtask

    // Raise the select, check selection and return data, toggle the serial
    // lines mid-frame, check nothing moved, then drop the select.
    task automatic frame(input int toggles);
        logic [3:0] a;
        a = model_sr[3:0];
        ctl_sel = 1'b1;
        wait_clk(3);
        chk("R5/R6 select", per_sel_n, exp_sel(a, 1'b1));
        for (int p = 0; p < 2; p++) begin
            per_miso = 16'($urandom);
            #1;
            chk("R7 miso route", {15'd0, ctl_miso}, {15'd0, exp_miso(a, 1'b1, per_miso)});
        end
        for (int t = 0; t < toggles; t++) begin
            ctl_mosi = 1'($urandom);
            wait_clk(3);
            ctl_sclk = 1'b1;
            wait_clk(3);
            ctl_sclk = 1'b0;
            wait_clk(2);
        end
        chk("R3 hold in frame", per_sel_n, exp_sel(a, 1'b1));
        ctl_sel = 1'b0;
        wait_clk(3);
        chk("R6 idle high", per_sel_n, 16'hFFFF);
        per_miso = 16'($urandom) | 16'h1;
        #1;
        chk("R8 miso idle", {15'd0, ctl_miso}, 16'd0);
    endtask

    initial begin
        process::self().srandom(32'h5EED_0C5A);
        wait_clk(4);
        chk("R1 reset sel", per_sel_n, 16'hFFFF);
        chk("R1 reset miso", {15'd0, ctl_miso}, 16'd0);
        rst_n = 1'b1;
        wait_clk(2);
        // R1: reset address 0 becomes visible in the first frame.
        ctl_sel = 1'b1;
        wait_clk(3);
        chk("R1 reset addr", per_sel_n, exp_sel(4'd0, 1'b1));
        ctl_sel = 1'b0;
        wait_clk(3);

        // R2 / R5: directed bank-boundary addresses.
        send_bits(4, 8'd3);  frame(0);
        send_bits(4, 8'd7);  frame(2);
        send_bits(4, 8'd8);  frame(1);
        send_bits(4, 8'd15); frame(3);
        // R4: six bits, upper two ignored -> address 5.
        send_bits(6, 8'b110101); frame(0);
        chk("R4 model addr", {12'd0, model_sr[3:0]}, 16'd5);
        // R2: partial shift of two bits on top of history 0101 -> 0110.
        send_bits(2, 8'b10); frame(1);

        // Constrained random lengths and values.
        for (int it = 0; it < 40; it++) begin
            send_bits(1 + int'($urandom_range(7)), 8'($urandom));
            frame(int'($urandom_range(3)));
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule